// File: doc/BRIEF.md
# Multidrop Serial Transceiver with Address-Frame Marking

This block is an asynchronous serial transmitter and receiver for a shared line that has one master and several slaves. In multidrop operation every frame carries one extra marker bit after the eight data bits. A marker of 1 flags the frame as an address (ID) frame, and a marker of 0 flags it as a data frame. The master sets the marker it sends through a control input. A slave that is waiting to be addressed sets its receive filter so that only address frames reach software. Once software finds that the received ID is its own, it clears the filter and data frames flow normally. Slaves that were not addressed keep the filter set, so the data traffic meant for another node never disturbs them.

Bytes enter and leave through valid/ready streams. The transmit side accepts a byte on any clock where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole frame, which is how the transmitter applies back-pressure. The receive side presents a byte with `rx_valid` and holds the data until the consumer raises `rx_ready`. A frame that completes while the previous byte is still unread is lost and reported as an overrun. The transmit pin is driven as a data value plus an output enable. With open-drain operation selected, a slave pulls the line low for a 0 and releases it for a 1, so several slaves can share one wired-AND line that has a pull-up.

Top module: `mdu_uart`

## Requirements
- R1: After reset `tx_ready`=1, `rx_valid`=0, `irq`=0, `err_frame`=0, `err_overrun`=0, and the resolved transmit line is high.
- R2: A transmitted frame is a start bit (0), then 8 data bits LSB first, then in multidrop mode (`cfg_mode[1]`=1) the marker bit, then a stop bit (1). Each bit lasts 16×`TICK_DIV` clocks.
- R3: The transmitted marker equals `cfg_tx_wake` as sampled on the clock where the byte is accepted. When `cfg_mode[1]`=0 no marker bit is sent, and the stop bit follows the data directly.
- R4: `tx_ready` goes low on the clock after a byte is accepted and stays low until the stop bit has ended.
- R5: A received frame with a valid stop bit is presented on `rx_data` with `rx_valid`=1. `rx_wake` carries the received marker in multidrop mode and is 0 when `cfg_mode[1]`=0, where the frame has no marker bit and the filter has no effect.
- R6: In multidrop mode with `cfg_rx_wake`=1, a frame with marker 0 is discarded: `rx_valid` stays 0, `irq` does not pulse, and `rx_data` keeps its previous value.
- R7: In multidrop mode with `cfg_rx_wake`=1, a frame with marker 1 is accepted with `rx_wake`=1. With `cfg_rx_wake`=0, frames are accepted whatever their marker.
- R8: `irq` pulses high for exactly one clock for each frame accepted into the receive register.
- R9: While `rx_valid`=1 and `rx_ready`=0, `rx_data` and `rx_valid` hold. A frame that completes in that state is dropped, `err_overrun` pulses for one clock, and the held byte is kept.
- R10: A stop bit sampled as 0 makes `err_frame` pulse for one clock, and the frame is discarded whatever its marker.
- R11: With `cfg_od_en`=1, `txd_o` is 0 and `txd_oe` is high only while the bit being sent is 0. With `cfg_od_en`=0, `txd_oe`=1 and `txd_o` equals the bit being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Framing mode; bit 1 set selects multidrop framing |
| cfg_tx_wake | input | 1 | Marker value for transmitted frames (1 = address) |
| cfg_rx_wake | input | 1 | Receive filter: accept address frames only |
| cfg_od_en | input | 1 | Open-drain drive of the transmit pin |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Received byte |
| rx_wake | output | 1 | Marker bit of the received byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| irq | output | 1 | One-clock pulse per accepted frame |
| err_frame | output | 1 | One-clock pulse on a bad stop bit |
| err_overrun | output | 1 | One-clock pulse on a frame lost to an unread byte |
| rxd | input | 1 | Serial receive line |
| txd_o | output | 1 | Transmit pin data value |
| txd_oe | output | 1 | Transmit pin output enable |

## Verification
A receive filter stuck in the wrong state shows up at the ports within a single frame time. A data frame then raises `rx_valid` and `irq` near the middle of its stop bit, or an address frame is never presented. A transmit shift register or bit counter that goes wrong changes the value on the line at one of the mid-bit sample points of the frame that is currently going out, or it moves the rise of `tx_ready` by a whole bit time. An overrun fault is visible as a changed `rx_data` while the consumer is holding off.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int OVS      = 16;
  localparam int OVS_W    = $clog2(OVS);
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_WAITHI} rx_state_t;

  // number of bits after the start bit: data, optional marker, stop
  function automatic logic [IDX_W-1:0] tail_bits(input logic multidrop);
    return multidrop ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  endfunction
endpackage

// File: rtl/mdu_tick.sv
module mdu_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              multidrop,
  input  logic              wake,
  input  logic [DATA_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              line
);
  localparam int SH_W = DATA_W + 3;

  logic             busy;
  logic [SH_W-1:0]  sh;
  logic [IDX_W-1:0] idx, last;
  logic [OVS_W-1:0] tcnt;

  assign ready = !busy;
  assign line  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      idx  <= '0;
      last <= '0;
      tcnt <= '0;
    end else if (!busy) begin
      if (valid) begin
        busy <= 1'b1;
        sh   <= {1'b1, (multidrop ? wake : 1'b1), data, 1'b0};
        last <= tail_bits(multidrop);
        idx  <= '0;
        tcnt <= '0;
      end
    end else if (tick) begin
      if (tcnt == OVS_W'(OVS - 1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[SH_W-1:1]};
        if (idx == last) busy <= 1'b0;
        else             idx  <= idx + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R4
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !ready);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> line);
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              multidrop,
  input  logic              filter_on,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_wake,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  output logic              err_frame,
  output logic              err_overrun
);
  rx_state_t        st;
  logic             s1, s2, md_f;
  logic [OVS_W-1:0] tcnt;
  logic [IDX_W-1:0] idx;
  logic [DATA_W:0]  bits;
  logic             done, ferr, drop, take;

  assign done = (st == RX_BITS) && tick && (tcnt == OVS_W'(OVS - 1)) &&
                (idx == tail_bits(md_f) - 1'b1);
  assign ferr = !s2;
  assign drop = md_f && filter_on && !bits[DATA_W];
  assign take = done && !ferr && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      idx  <= '0;
      bits <= '0;
      md_f <= 1'b0;
    end else if (tick) begin
      unique case (st)
        RX_IDLE: if (!s2) begin
          st   <= RX_START;
          tcnt <= '0;
          md_f <= multidrop;
        end
        RX_START: if (tcnt == OVS_W'(OVS / 2 - 1)) begin
          st   <= s2 ? RX_IDLE : RX_BITS;
          tcnt <= '0;
          idx  <= '0;
        end else tcnt <= tcnt + 1'b1;
        RX_BITS: if (tcnt == OVS_W'(OVS - 1)) begin
          tcnt <= '0;
          if (done) st <= s2 ? RX_IDLE : RX_WAITHI;
          else begin
            if (idx <= IDX_W'(DATA_W)) bits[idx] <= s2;
            idx <= idx + 1'b1;
          end
        end else tcnt <= tcnt + 1'b1;
        RX_WAITHI: if (s2) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_wake     <= 1'b0;
      rx_valid    <= 1'b0;
      irq         <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      irq         <= 1'b0;
      err_overrun <= 1'b0;
      err_frame   <= done && ferr;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (take) begin
        if (rx_valid && !rx_ready) begin
          err_overrun <= 1'b1;
        end else begin
          rx_data  <= bits[DATA_W-1:0];
          rx_wake  <= md_f && bits[DATA_W];
          rx_valid <= 1'b1;
          irq      <= 1'b1;
        end
      end
    end
  end

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_wake)));
  // R8
  irq_with_new_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> irq);
  // R6
  filter_passes_address_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(md_f && filter_on)) |-> rx_wake);
  // R10
  frame_error_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |-> !irq);
endmodule

// File: rtl/mdu_uart.sv
module mdu_uart
  import mdu_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_tx_wake,
  input  logic              cfg_rx_wake,
  input  logic              cfg_od_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_wake,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  output logic              err_frame,
  output logic              err_overrun,
  input  logic              rxd,
  output logic              txd_o,
  output logic              txd_oe
);
  logic tick, line;
  logic multidrop;

  assign multidrop = cfg_mode[1];

  mdu_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  mdu_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .multidrop(multidrop),
    .wake(cfg_tx_wake), .data(tx_data), .valid(tx_valid),
    .ready(tx_ready), .line(line)
  );

  mdu_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .multidrop(multidrop),
    .filter_on(cfg_rx_wake), .rxd(rxd), .rx_data(rx_data),
    .rx_wake(rx_wake), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .irq(irq), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  assign txd_o  = cfg_od_en ? 1'b0 : line;
  assign txd_oe = cfg_od_en ? !line : 1'b1;

  // R11
  od_release_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_od_en && tx_ready) |-> !txd_oe);
endmodule

// File: tb/test_mdu_uart.sv
module test_mdu_uart;
  localparam int TICK_DIV = 4;
  localparam int BITC = 16 * TICK_DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b10;
  logic cfg_tx_wake = 1'b0, cfg_rx_wake = 1'b0, cfg_od_en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, rx_ready = 1'b0, rxd = 1'b1;
  logic tx_ready, rx_wake, rx_valid, irq, err_frame, err_overrun, txd_o, txd_oe;
  logic [7:0] rx_data;
  logic tline;

  int checks = 0, fails = 0;
  int irq_cnt = 0, fe_cnt = 0, ov_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign tline = txd_oe ? txd_o : 1'b1;

  mdu_uart #(.TICK_DIV(TICK_DIV)) i_mdu_uart (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_tx_wake(cfg_tx_wake),
    .cfg_rx_wake(cfg_rx_wake), .cfg_od_en(cfg_od_en), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_wake(rx_wake), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
    .err_frame(err_frame), .err_overrun(err_overrun), .rxd(rxd),
    .txd_o(txd_o), .txd_oe(txd_oe)
  );

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (err_frame) fe_cnt <= fe_cnt + 1;
    if (err_overrun) ov_cnt <= ov_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic send_frame(input bit md, input logic [7:0] d, input bit w, input bit stp);
    @(negedge clk) rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BITC) @(negedge clk);
    end
    if (md) begin
      rxd = w;
      repeat (BITC) @(negedge clk);
    end
    rxd = stp;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic consume();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  // sends one byte and checks the line at every mid-bit point
  task automatic tx_frame(input bit md, input bit w, input logic [7:0] d, input bit od);
    logic [10:0] exp;
    int n;
    exp = md ? {1'b1, w, d, 1'b0} : {2'b11, d, 1'b0};
    n = md ? 11 : 10;
    cfg_mode = md ? 2'b10 : 2'b00;
    cfg_tx_wake = w;
    cfg_od_en = od;
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R4 ready low after accept", tx_ready, 0);
    cfg_tx_wake = !w;
    repeat (BITC / 2 - 1) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(tline == exp[i], "R2/R3 line bit", tline, exp[i]);
      if (od) chk(txd_o == 1'b0 && txd_oe == !exp[i], "R11 open-drain drive", {txd_o, txd_oe}, {1'b0, !exp[i]});
      else    chk(txd_oe == 1'b1 && txd_o == exp[i], "R11 push-pull drive", {txd_o, txd_oe}, {exp[i], 1'b1});
      if (i < n - 1) repeat (BITC) @(negedge clk);
    end
    chk(tx_ready == 1'b0, "R4 busy in stop bit", tx_ready, 0);
    repeat (BITC / 2 + 8) @(negedge clk);
    chk(tx_ready == 1'b1, "R4 ready after stop", tx_ready, 1);
  endtask

  // mode, filter, data, marker, stop, accept, frame error
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {2'b10, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b11, 1'b0, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'b00, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b01, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] held;
    int i0, f0, o0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tx_ready && !rx_valid && !irq && !err_frame && !err_overrun && tline,
        "R1 reset state", {tx_ready, rx_valid, irq, err_frame, err_overrun, tline}, 6'b100001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    held = rx_data;

    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      logic [7:0] d;
      bit fl, w, stp, acc, fe;
      {m, fl, d, w, stp, acc, fe} = VEC[v];
      cfg_mode = m;
      cfg_rx_wake = fl;
      i0 = irq_cnt;
      f0 = fe_cnt;
      send_frame(m[1], d, w, stp);
      chk(rx_valid == acc, "R6/R7/R10 accept decision", rx_valid, acc);
      chk(irq_cnt - i0 == int'(acc), "R8 one irq per accepted frame", irq_cnt - i0, acc);
      chk(fe_cnt - f0 == int'(fe), "R10 frame error pulse", fe_cnt - f0, fe);
      if (acc) begin
        chk(rx_data == d, "R5 received byte", rx_data, d);
        chk(rx_wake == (m[1] & w), "R5/R7 received marker", rx_wake, m[1] & w);
        held = d;
        consume();
        @(negedge clk);
        chk(!rx_valid, "R5 valid drops after ready", rx_valid, 0);
      end else begin
        chk(rx_data == held, "R6 rx_data unchanged on discard", rx_data, held);
      end
    end

    // R9 overrun: two frames without reading
    cfg_mode = 2'b10;
    cfg_rx_wake = 1'b0;
    i0 = irq_cnt;
    o0 = ov_cnt;
    send_frame(1'b1, 8'h11, 1'b0, 1'b1);
    send_frame(1'b1, 8'h22, 1'b1, 1'b1);
    chk(rx_valid && rx_data == 8'h11, "R9 held byte kept", rx_data, 8'h11);
    chk(ov_cnt - o0 == 1, "R9 overrun pulse", ov_cnt - o0, 1);
    chk(irq_cnt - i0 == 1, "R8 no irq for dropped byte", irq_cnt - i0, 1);
    consume();

    // transmit paths
    tx_frame(1'b1, 1'b1, 8'h6B, 1'b0);
    tx_frame(1'b1, 1'b0, 8'hC4, 1'b0);
    tx_frame(1'b0, 1'b1, 8'h96, 1'b0);
    tx_frame(1'b1, 1'b0, 8'h0F, 1'b1);
    chk(txd_oe == 1'b0 && tline == 1'b1, "R11 released when idle", txd_oe, 0);

    finish_run();
  end
endmodule